// File: doc/BRIEF.md
# Privatized Parallel Byte Histogram Engine

This block counts how often each byte value occurs in a job of input elements and accumulates the counts into a global table of 256 bins. Several lanes work side by side. Each beat of the input stream carries as many consecutive elements as there are lanes, and lane i always takes element i of the beat. So lane i handles elements i, i+S, i+2S and so on, where S is the lane count. Lanes are split into groups. Each group owns a private bin table that it alone updates, which keeps contention on the shared table away from the counting loop.

A job runs in fixed phases. First the private tables are swept to zero, one bin per cycle. Next the stream is accepted until the requested element count has been consumed. Then every bin of the global table is updated once with the sum of the private values for that bin. A one-cycle done pulse ends the job. The global table is not cleared by a job, so results add up across jobs until a separate clear command is given while the engine is idle. A registered read port returns any global bin.

Top module: `hist_engine`

## Requirements
- R1: Each accepted element whose position is below the job length adds exactly 1 to the bin whose index equals its byte value.
- R2: A start pulse accepted while idle first clears the private tables over 256 cycles. in_ready_o stays low during those cycles and rises in the 256th cycle after the start edge.
- R3: In a beat, byte lane i (in_data_i bits [8i+7:8i]) carries element number kS+i of the job. Lanes 2g and 2g+1 belong to group g. Lanes whose element number is not below the job length are ignored.
- R4: in_ready_o is high only in the counting phase while elements remain. in_valid_i has no effect while in_ready_o is low, and merging starts only after all elements have been consumed.
- R5: When several lanes of one group carry the same byte in one beat, every one of them is counted.
- R6: The merge adds each private bin once into the global bin with the same index. The result does not depend on how elements were spread over the lanes.
- R7: Private and global counters saturate at all ones and never wrap.
- R8: done_o is a single-cycle pulse after the merge, and busy_o is low in the cycle after it. busy_o is high from the cycle after start, and a start while busy has no effect.
- R9: The global table keeps its values across jobs. glb_clr_i while idle zeros every global bin; while busy it is ignored.
- R10: A job length of zero accepts no element, still produces done_o, and leaves every global bin unchanged.
- R11: rd_data_o returns the global bin selected by rd_addr_i one cycle after the address is presented. After reset every bin reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a job (honoured while idle) |
| job_len_i | input | LEN_W | Number of elements in the job, sampled with start_i |
| glb_clr_i | input | 1 | Zero the global table (honoured while idle) |
| in_valid_i | input | 1 | Input beat valid |
| in_data_i | input | LANES*BIN_W | One byte per lane, lane 0 in the low byte |
| in_ready_o | output | 1 | Engine accepts a beat |
| rd_addr_i | input | BIN_W | Global bin to read |
| rd_data_o | output | CNT_W | Registered global bin value |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle pulse at job end |

## Verification
The bench goes after a final beat that is only partly filled. Padding bytes there must not be counted, and a design that ignored the length would raise the padding bin. It sends beats in which every lane of a group carries the same byte, which a design that kept only one write per bin would undercount. It holds in_valid_i high with a marker byte during the clear phase and during a zero-length job, which exposes a design that accepts data early. It also arranges one byte value to reach more than the counter range inside a single group, so a design whose private counters wrap would merge a small value instead of the saturated one. A start or a clear raised during the merge must change neither the done count nor the table.

// File: rtl/hist_pkg.sv
package hist_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CLEAR = 3'd1,
      ST_COUNT = 3'd2,
      ST_MERGE = 3'd3,
      ST_FIN   = 3'd4
   } hist_state_e;

endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
   import hist_pkg::*;
#(
   parameter int LANES = 4,
   parameter int BIN_W = 8,
   parameter int LEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] job_len_i,
   input  logic             in_valid_i,
   output logic             in_ready_o,
   output logic [LANES-1:0] lane_vld_o,
   output logic             clr_en_o,
   output logic             merge_en_o,
   output logic [BIN_W-1:0] idx_o,
   output logic             busy_o,
   output logic             done_o,
   output hist_state_e      st_o
);

   localparam int              NUM_BINS = 1 << BIN_W;
   localparam logic [BIN_W-1:0] LAST_IDX = BIN_W'(NUM_BINS - 1);
   localparam logic [LEN_W-1:0] BEAT_LEN = LEN_W'(LANES);

   hist_state_e      st_q;
   logic [BIN_W-1:0] idx_q;
   logic [LEN_W-1:0] rem_q;
   logic             beat;
   logic [LEN_W-1:0] take;

   assign in_ready_o = (st_q == ST_COUNT) && (rem_q != '0);
   assign beat       = in_valid_i && in_ready_o;
   assign take       = (rem_q >= BEAT_LEN) ? BEAT_LEN : rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         rem_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  rem_q <= job_len_i;
                  idx_q <= '0;
                  st_q  <= ST_CLEAR;
               end
            end
            ST_CLEAR: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) begin
                  st_q <= ST_COUNT;
               end
            end
            ST_COUNT: begin
               if (rem_q == '0) begin
                  idx_q <= '0;
                  st_q  <= ST_MERGE;
               end else if (beat) begin
                  rem_q <= rem_q - take;
               end
            end
            ST_MERGE: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) begin
                  st_q <= ST_FIN;
               end
            end
            ST_FIN: begin
               st_q <= ST_IDLE;
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane_vld
      assign lane_vld_o[i] = beat && (rem_q > LEN_W'(i));
   end

   assign clr_en_o   = (st_q == ST_CLEAR);
   assign merge_en_o = (st_q == ST_MERGE);
   assign idx_o      = idx_q;
   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = (st_q == ST_FIN);
   assign st_o       = st_q;

endmodule

// File: rtl/hist_priv_bank.sv
module hist_priv_bank #(
   parameter int LPG   = 2,
   parameter int BIN_W = 8,
   parameter int CNT_W = 32
) (
   input  logic                 clk,
   input  logic                 clr_en_i,
   input  logic [BIN_W-1:0]     idx_i,
   input  logic [LPG-1:0]       vld_i,
   input  logic [LPG*BIN_W-1:0] bin_i,
   output logic [CNT_W-1:0]     cnt_o
);

   localparam int NUM_BINS = 1 << BIN_W;
   localparam int INC_W    = $clog2(LPG + 1);

   logic [CNT_W-1:0] mem [NUM_BINS];

   function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] v,
                                                input logic [INC_W-1:0] d);
      logic [CNT_W:0] s;
      s = {1'b0, v} + (CNT_W + 1)'(d);
      return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
   endfunction

   if (LPG == 1) begin : g_single
      // one lane per group: no same-cycle collisions are possible
      always_ff @(posedge clk) begin
         if (clr_en_i) begin
            mem[idx_i] <= '0;
         end else if (vld_i[0]) begin
            mem[bin_i[BIN_W-1:0]] <= sat_add(mem[bin_i[BIN_W-1:0]], INC_W'(1));
         end
      end
   end else begin : g_multi
      logic [INC_W-1:0] inc [LPG];
      logic [LPG-1:0]   own;

      // the lowest lane hitting a bin owns the write and carries the total
      always_comb begin
         for (int j = 0; j < LPG; j++) begin
            inc[j] = '0;
            own[j] = vld_i[j];
            for (int k = 0; k < LPG; k++) begin
               if (vld_i[k] && (bin_i[k*BIN_W +: BIN_W] == bin_i[j*BIN_W +: BIN_W])) begin
                  inc[j] = inc[j] + INC_W'(1);
                  if (k < j) begin
                     own[j] = 1'b0;
                  end
               end
            end
         end
      end

      always_ff @(posedge clk) begin
         if (clr_en_i) begin
            mem[idx_i] <= '0;
         end else begin
            for (int j = 0; j < LPG; j++) begin
               if (own[j]) begin
                  mem[bin_i[j*BIN_W +: BIN_W]] <= sat_add(mem[bin_i[j*BIN_W +: BIN_W]], inc[j]);
               end
            end
         end
      end
   end

   assign cnt_o = mem[idx_i];

endmodule

// File: rtl/hist_global.sv
module hist_global #(
   parameter int GROUPS = 2,
   parameter int BIN_W  = 8,
   parameter int CNT_W  = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    merge_en_i,
   input  logic [BIN_W-1:0]        idx_i,
   input  logic [GROUPS*CNT_W-1:0] priv_i,
   input  logic [BIN_W-1:0]        rd_addr_i,
   output logic [CNT_W-1:0]        rd_data_o
);

   localparam int             NUM_BINS = 1 << BIN_W;
   localparam int             SUM_W    = CNT_W + $clog2(GROUPS + 1);
   localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

   logic [CNT_W-1:0] tbl [NUM_BINS];
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] merged;

   always_comb begin
      sum = SUM_W'(tbl[idx_i]);
      for (int g = 0; g < GROUPS; g++) begin
         sum = sum + SUM_W'(priv_i[g*CNT_W +: CNT_W]);
      end
      merged = (sum > CNT_MAX) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BINS; b++) begin
            tbl[b] <= '0;
         end
         rd_data_o <= '0;
      end else begin
         if (clr_i) begin
            for (int b = 0; b < NUM_BINS; b++) begin
               tbl[b] <= '0;
            end
         end else if (merge_en_i) begin
            tbl[idx_i] <= merged;
         end
         rd_data_o <= tbl[rd_addr_i];
      end
   end

endmodule

// File: rtl/hist_engine.sv
module hist_engine
   import hist_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int GROUPS = 2,
   parameter int BIN_W  = 8,
   parameter int CNT_W  = 32,
   parameter int LEN_W  = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [LEN_W-1:0]       job_len_i,
   input  logic                   glb_clr_i,
   input  logic                   in_valid_i,
   input  logic [LANES*BIN_W-1:0] in_data_i,
   output logic                   in_ready_o,
   input  logic [BIN_W-1:0]       rd_addr_i,
   output logic [CNT_W-1:0]       rd_data_o,
   output logic                   busy_o,
   output logic                   done_o
);

   localparam int LPG = LANES / GROUPS;

   if (LANES < 1 || GROUPS < 1 || (LANES % GROUPS) != 0) begin : g_chk_lanes
      $error("hist_engine: LANES must be a positive multiple of GROUPS");
   end
   if (CNT_W < 2 || BIN_W < 1 || LEN_W < 2) begin : g_chk_widths
      $error("hist_engine: widths too small");
   end

   hist_state_e          st;
   logic [LANES-1:0]     lane_vld;
   logic                 clr_en;
   logic                 merge_en;
   logic [BIN_W-1:0]     idx;
   logic [GROUPS*CNT_W-1:0] priv_cnt;
   logic                 glb_clr_ok;

   hist_ctrl #(
      .LANES (LANES),
      .BIN_W (BIN_W),
      .LEN_W (LEN_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .job_len_i  (job_len_i),
      .in_valid_i (in_valid_i),
      .in_ready_o (in_ready_o),
      .lane_vld_o (lane_vld),
      .clr_en_o   (clr_en),
      .merge_en_o (merge_en),
      .idx_o      (idx),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .st_o       (st)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      hist_priv_bank #(
         .LPG   (LPG),
         .BIN_W (BIN_W),
         .CNT_W (CNT_W)
      ) u_bank (
         .clk      (clk),
         .clr_en_i (clr_en),
         .idx_i    (idx),
         .vld_i    (lane_vld[g*LPG +: LPG]),
         .bin_i    (in_data_i[g*LPG*BIN_W +: LPG*BIN_W]),
         .cnt_o    (priv_cnt[g*CNT_W +: CNT_W])
      );
   end

   assign glb_clr_ok = glb_clr_i && !busy_o;

   hist_global #(
      .GROUPS (GROUPS),
      .BIN_W  (BIN_W),
      .CNT_W  (CNT_W)
   ) u_global (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (glb_clr_ok),
      .merge_en_i (merge_en),
      .idx_i      (idx),
      .priv_i     (priv_cnt),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (rd_data_o)
   );

endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk
   import hist_pkg::*;
#(
   parameter int LANES = 4,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             glb_clr_i,
   input logic             in_valid_i,
   input logic             in_ready_o,
   input logic [CNT_W-1:0] rd_data_o,
   input logic             busy_o,
   input logic             done_o,
   input hist_state_e      st,
   input logic [LANES-1:0] lane_vld
);

   // R4: data is taken only in the counting phase
   a_r4_ready_in_count: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> (st == ST_COUNT));

   // R2: counting is entered only from the clear sweep
   a_r2_count_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COUNT && $past(st) != ST_COUNT) |-> ($past(st) == ST_CLEAR));

   // R4: merging is entered only from counting
   a_r4_merge_after_count: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MERGE && $past(st) != ST_MERGE) |-> ($past(st) == ST_COUNT));

   // R3: valid lanes form a prefix starting at lane 0
   a_r3_lane_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      ((lane_vld + LANES'(1)) & lane_vld) == '0);

   // R3: a lane counts only on an accepted beat
   a_r3_lane_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_vld) |-> (in_valid_i && in_ready_o));

   // R8: done is a single-cycle pulse followed by idle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   // R8: a start while busy does not end the job early
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && start_i) |=> busy_o);

   // R9: an idle clear makes the read port return zero
   a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_clr_i && !busy_o) |=> ##1 (rd_data_o == '0));

endmodule

bind hist_engine hist_engine_chk #(
   .LANES (LANES),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .glb_clr_i  (glb_clr_i),
   .in_valid_i (in_valid_i),
   .in_ready_o (in_ready_o),
   .rd_data_o  (rd_data_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .st         (st),
   .lane_vld   (lane_vld)
);

// File: tb/hist_engine_bench.sv
`timescale 1ns/1ps
module hist_engine_bench;

   localparam int LANES  = 4;
   localparam int GROUPS = 2;
   localparam int BIN_W  = 8;
   localparam int CNT_W  = 8;
   localparam int LEN_W  = 32;
   localparam int NB     = 256;
   localparam int MAXV   = 255;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   start_i = 1'b0;
   logic [LEN_W-1:0]       job_len_i = '0;
   logic                   glb_clr_i = 1'b0;
   logic                   in_valid_i = 1'b0;
   logic [LANES*BIN_W-1:0] in_data_i = '0;
   logic                   in_ready_o;
   logic [BIN_W-1:0]       rd_addr_i = '0;
   logic [CNT_W-1:0]       rd_data_o;
   logic                   busy_o;
   logic                   done_o;

   hist_engine #(
      .LANES (LANES), .GROUPS (GROUPS), .BIN_W (BIN_W),
      .CNT_W (CNT_W), .LEN_W (LEN_W)
   ) u_hist_engine (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .job_len_i (job_len_i),
      .glb_clr_i (glb_clr_i), .in_valid_i (in_valid_i), .in_data_i (in_data_i),
      .in_ready_o (in_ready_o), .rd_addr_i (rd_addr_i), .rd_data_o (rd_data_o),
      .busy_o (busy_o), .done_o (done_o)
   );

   always #2.5 clk = ~clk;

   int  nchk = 0;
   int  nfail = 0;
   bit  finished = 1'b0;
   int  gexp [NB];
   logic [7:0] elems [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard: read driver pushes expectations, monitor pops them
   logic  rd_req = 1'b0;
   logic  req_d = 1'b0;
   int    sb_q [$];
   string sb_tag [$];

   always @(posedge clk) req_d <= rd_req;

   always @(negedge clk) begin
      if (req_d) begin
         int    e;
         string t;
         e = sb_q.pop_front();
         t = sb_tag.pop_front();
         chk(int'(rd_data_o) == e, t, int'(rd_data_o), e);
      end
   end

   task automatic rd_check(input int addr, input string tag);
      @(negedge clk);
      rd_addr_i = BIN_W'(addr);
      rd_req    = 1'b1;
      sb_q.push_back(gexp[addr]);
      sb_tag.push_back(tag);
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic load_str(input string s);
      elems.delete();
      for (int i = 0; i < s.len(); i++) elems.push_back(s[i]);
   endtask

   // model: lane = position mod 4, group = lane / 2, saturating everywhere
   task automatic model_job(input int len);
      int pc [GROUPS][NB];
      for (int g = 0; g < GROUPS; g++)
         for (int b = 0; b < NB; b++) pc[g][b] = 0;
      for (int p = 0; p < len; p++) begin
         int gp;
         gp = (p % LANES) / (LANES / GROUPS);
         if (pc[gp][elems[p]] < MAXV) pc[gp][elems[p]]++;
      end
      for (int b = 0; b < NB; b++) begin
         int s;
         s = gexp[b];
         for (int g = 0; g < GROUPS; g++) s += pc[g][b];
         gexp[b] = (s > MAXV) ? MAXV : s;
      end
   endtask

   task automatic run_job(input int len, input bit poke_mid, input bit bubbles);
      int w;
      int p;
      int beat;
      int dn;
      @(negedge clk);
      start_i    = 1'b1;
      job_len_i  = LEN_W'(len);
      in_valid_i = 1'b1;                   // marker data offered early (R4)
      in_data_i  = {LANES{8'h77}};
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
      chk(in_ready_o == 1'b0, "R2 not ready while clearing", int'(in_ready_o), 0);
      if (len > 0) begin
         w = 0;
         while (!in_ready_o && w < 1000) begin
            @(negedge clk);
            w++;
         end
         chk(w == 256, "R2 clear sweep length", w, 256);
      end
      p = 0;
      beat = 0;
      while (p < len) begin
         if (bubbles && (beat % 3 == 1)) begin
            in_valid_i = 1'b0;
            @(negedge clk);
         end
         in_valid_i = 1'b1;
         for (int i = 0; i < LANES; i++)
            in_data_i[i*8 +: 8] = (p + i < len) ? elems[p + i] : 8'hEE;
         while (!in_ready_o) @(negedge clk);
         @(negedge clk);
         p += LANES;
         beat++;
      end
      if (len > 0) in_valid_i = 1'b0;
      if (poke_mid) begin
         start_i   = 1'b1;                  // ignored: engine is busy (R8)
         job_len_i = 32'd7;
         glb_clr_i = 1'b1;                  // ignored: engine is busy (R9)
         @(negedge clk);
         start_i   = 1'b0;
         glb_clr_i = 1'b0;
      end
      dn = 0;
      w  = 0;
      while (!done_o && w < 2000) begin
         @(negedge clk);
         w++;
      end
      if (done_o) dn++;
      @(negedge clk);
      in_valid_i = 1'b0;
      chk(dn == 1, "R8 done seen", dn, 1);
      chk(done_o == 1'b0, "R8 done single cycle", int'(done_o), 0);
      chk(busy_o == 1'b0, "R8 idle after done", int'(busy_o), 0);
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R8 no restart from ignored start", int'(busy_o), 0);
      model_job(len);
   endtask

   initial begin
      for (int b = 0; b < NB; b++) gexp[b] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0, "R8 reset busy", int'(busy_o), 0);
      chk(done_o == 1'b0, "R8 reset done", int'(done_o), 0);
      chk(in_ready_o == 1'b0, "R4 reset ready", int'(in_ready_o), 0);
      rd_check(0, "R11 reset bin 0");
      rd_check(255, "R11 reset bin 255");

      // mixed text, partial last beat (14 elements)
      load_str("HISTOGRAM BINS");
      run_job(14, 1'b0, 1'b0);
      rd_check("H", "R1 bin H");
      rd_check("I", "R1 bin I");
      rd_check("S", "R1 bin S");
      rd_check("M", "R1 bin M");
      rd_check(" ", "R1 bin space");
      rd_check("N", "R1 bin N");
      rd_check(8'hEE, "R3 padding ignored");
      rd_check(8'h77, "R4 early data ignored");

      // all lanes same byte: conflicts inside both groups
      elems.delete();
      for (int i = 0; i < 8; i++) elems.push_back(8'h41);
      run_job(8, 1'b0, 1'b0);
      rd_check(8'h41, "R5 same-bin same-cycle");

      // conflict in group 0 only, with stall bubbles
      elems.delete();
      for (int i = 0; i < 3; i++) begin
         elems.push_back(8'h50); elems.push_back(8'h50);
         elems.push_back(8'h51); elems.push_back(8'h52);
      end
      run_job(12, 1'b0, 1'b1);
      rd_check(8'h50, "R5 group0 collision");
      rd_check(8'h51, "R3 lane2 element");
      rd_check(8'h52, "R3 lane3 element");

      // rerun the text job: accumulation; start and clear during merge ignored
      load_str("HISTOGRAM BINS");
      run_job(14, 1'b1, 1'b1);
      rd_check("S", "R9 accumulate S");
      rd_check("O", "R9 accumulate O");
      rd_check(8'h41, "R9 clear while busy ignored");

      // zero length job
      run_job(0, 1'b0, 1'b0);
      rd_check("S", "R10 zero length unchanged");
      rd_check(8'h77, "R10 no element taken");

      // idle clear
      @(negedge clk);
      glb_clr_i = 1'b1;
      @(negedge clk);
      glb_clr_i = 1'b0;
      for (int b = 0; b < NB; b++) gexp[b] = 0;
      rd_check("S", "R9 cleared S");
      rd_check(8'h41, "R9 cleared 0x41");

      // merge saturation: 150 per group, sum beyond range
      elems.delete();
      for (int i = 0; i < 300; i++) elems.push_back(8'h11);
      run_job(300, 1'b0, 1'b0);
      rd_check(8'h11, "R7 merge saturates");

      // private saturation: group 0 sees 300 of 0x22, group 1 300 of 0x33
      elems.delete();
      for (int i = 0; i < 600; i++) elems.push_back(((i % 4) < 2) ? 8'h22 : 8'h33);
      run_job(600, 1'b0, 1'b0);
      rd_check(8'h22, "R7 private saturates g0");
      rd_check(8'h33, "R6 merge once g1");

      // saturated global stays saturated
      elems.delete();
      for (int i = 0; i < 10; i++) elems.push_back(8'h11);
      run_job(10, 1'b0, 1'b1);
      rd_check(8'h11, "R7 saturated stays");
      rd_check(8'h10, "R6 neighbour bin untouched");

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule